// File: doc/BRIEF.md
# Multiplexed GPIO Pin Bank

This block is a bank of general-purpose pins controlled through a small word-addressed register port. Each pin has these controls:

- an output data bit;
- a direction bit;
- a pull control;
- a two-bit function select.

The function select hands the pad either to the GPIO logic or to one of three alternate peripherals. Software changes data and direction with whole-word writes. It can also use write-one-to-set and write-one-to-clear words, so a single pin changes without a read-modify-write.

The pull scheme has no separate up/down register. When the pull is enabled, the pin's output data bit picks its polarity. A sleep-control word decides, per pin, whether the pin holds its state while the sleep input is high. The alternative is that the pin becomes a pulled input for the duration of sleep. Pad levels pass through a two-flop synchronizer before software can read them.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset the pins are in this state:
  - `pad_oe_o` and `pull_en_o` are all zero.
  - The pull-disable (offset 3) and sleep-control (offset 7) words read all ones.
  - Output data, direction, A-select and B-select read zero.
- R2: A write to offset 1 sets the output data bits where `wdata_i` is 1. A write to offset 2 clears them there. Bits where `wdata_i` is 0 keep their value. Reads of offsets 1 and 2 return the output data word.
- R3: A write to offset 0 loads the whole output data word. A read of offset 0 returns the synchronized pad levels.
- R4: Direction works the same way, with 1 meaning output:
  - offset 4 is written whole and reads the direction word;
  - offset 5 sets bits;
  - offset 6 clears bits;
  - offsets 5 and 6 read the direction word.
- R5: Pin n's mode is {B-select bit n at offset 9, A-select bit n at offset 8}:
  - 00 is GPIO;
  - 01 is alternate A;
  - 10 is alternate B;
  - 11 is alternate C.
  Both select words read back what was written.
- R6: In GPIO mode, `pad_out_o[n]` is the output data bit and the output enable is the direction bit.
- R7: In an alternate mode, `pad_out_o[n]` and the output enable come from that function's `alt_*_out_i[n]` and `alt_*_oe_i[n]`.
- R8: `pull_up_o[n]` always equals the output data bit. Outside forced sleep, `pull_en_o[n]` is 1 only when both of these hold:
  - the pull-disable bit is 0;
  - the pin is not driving (`pad_oe_o[n]` is 0).
- R9: While `sleep_i` is 1, every pin whose sleep-control bit is 0 has `pad_oe_o` at 0 and `pull_en_o` at 1. Pins with a sleep-control bit of 1 keep their normal behaviour.
- R10: A pad level set before clock edge k reads at offset 0 after edge k+1, but not after edge k alone.
- R11: Offsets 10 to 15 read zero, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable, qualified by sel_i |
| addr_i | input | 4 | Word offset |
| wdata_i | input | NUM_PINS | Write data |
| rdata_o | output | NUM_PINS | Read data, combinational on addr_i |
| sleep_i | input | 1 | Sleep request |
| pad_in_i | input | NUM_PINS | Pad input levels |
| pad_out_o | output | NUM_PINS | Pad output levels |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| pull_en_o | output | NUM_PINS | Pull enables |
| pull_up_o | output | NUM_PINS | Pull polarity, 1 = up |
| alt_a_out_i | input | NUM_PINS | Alternate A output data |
| alt_a_oe_i | input | NUM_PINS | Alternate A output enables |
| alt_b_out_i | input | NUM_PINS | Alternate B output data |
| alt_b_oe_i | input | NUM_PINS | Alternate B output enables |
| alt_c_out_i | input | NUM_PINS | Alternate C output data |
| alt_c_oe_i | input | NUM_PINS | Alternate C output enables |

## Verification
The bench builds the bank with the default NUM_PINS of 32. A single random select word therefore spreads GPIO and all three alternate modes across different pins at the same time. With the full width, the set and clear masks can mix touched and untouched bits in every position. The sleep override can also split the bank between held pins and forced pins in one cycle. Random alternate-function inputs and random sleep toggling land on every mode and pull combination, including driving pins whose pull must stay off.

// File: rtl/gpio_mux_bank_pkg.sv
package gpio_mux_bank_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DATA    = 4'd0,
    OFF_DSET    = 4'd1,
    OFF_DCLR    = 4'd2,
    OFF_PDIS    = 4'd3,
    OFF_DIR     = 4'd4,
    OFF_DIRSET  = 4'd5,
    OFF_DIRCLR  = 4'd6,
    OFF_SLEEP   = 4'd7,
    OFF_ASEL    = 4'd8,
    OFF_BSEL    = 4'd9
  } reg_off_e;

  typedef enum logic [1:0] {
    MODE_GPIO  = 2'b00,
    MODE_ALT_A = 2'b01,
    MODE_ALT_B = 2'b10,
    MODE_ALT_C = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gmb_regfile.sv
module gmb_regfile
  import gpio_mux_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] dout_q_o,
  output logic [NUM_PINS-1:0] dir_q_o,
  output logic [NUM_PINS-1:0] pdis_q_o,
  output logic [NUM_PINS-1:0] keep_q_o,
  output logic [NUM_PINS-1:0] asel_q_o,
  output logic [NUM_PINS-1:0] bsel_q_o
);
  localparam logic [NUM_PINS-1:0] ONES = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q_o <= '0;
      dir_q_o  <= '0;
      pdis_q_o <= ONES;
      keep_q_o <= ONES;
      asel_q_o <= '0;
      bsel_q_o <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_DATA:   dout_q_o <= wdata_i;
        OFF_DSET:   dout_q_o <= dout_q_o | wdata_i;
        OFF_DCLR:   dout_q_o <= dout_q_o & ~wdata_i;
        OFF_PDIS:   pdis_q_o <= wdata_i;
        OFF_DIR:    dir_q_o  <= wdata_i;
        OFF_DIRSET: dir_q_o  <= dir_q_o | wdata_i;
        OFF_DIRCLR: dir_q_o  <= dir_q_o & ~wdata_i;
        OFF_SLEEP:  keep_q_o <= wdata_i;
        OFF_ASEL:   asel_q_o <= wdata_i;
        OFF_BSEL:   bsel_q_o <= wdata_i;
        default: ;
      endcase
    end
  end

  AST_DSET_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DSET) |=>
      ((dout_q_o & $past(wdata_i)) == $past(wdata_i)) &&
      (((dout_q_o ^ $past(dout_q_o)) & ~$past(wdata_i)) == '0)); // R2

  AST_DCLR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DCLR) |=>
      ((dout_q_o & $past(wdata_i)) == '0) &&
      (((dout_q_o ^ $past(dout_q_o)) & ~$past(wdata_i)) == '0)); // R2

  AST_DIRSET_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_DIRSET) |=>
      ((dir_q_o & $past(wdata_i)) == $past(wdata_i)) &&
      (((dir_q_o ^ $past(dir_q_o)) & ~$past(wdata_i)) == '0)); // R4

  AST_UNMAPPED_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i > OFF_BSEL) |=>
      $stable(dout_q_o) && $stable(dir_q_o) && $stable(pdis_q_o) &&
      $stable(keep_q_o) && $stable(asel_q_o) && $stable(bsel_q_o)); // R11
endmodule

// File: rtl/gmb_sync.sv
module gmb_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gmb_pin.sv
module gmb_pin
  import gpio_mux_bank_pkg::*;
(
  input  logic       dout_i,
  input  logic       dir_i,
  input  logic       pdis_i,
  input  logic       keep_i,
  input  logic       asel_i,
  input  logic       bsel_i,
  input  logic       sleep_i,
  input  logic [2:0] alt_out_i,  // {C, B, A}
  input  logic [2:0] alt_oe_i,
  output logic       out_o,
  output logic       oe_o,
  output logic       pull_en_o,
  output logic       pull_up_o
);
  pin_mode_e mode;
  logic      oe_n;
  logic      force_in;

  assign mode = pin_mode_e'({bsel_i, asel_i});

  always_comb begin
    case (mode)
      MODE_ALT_A: begin out_o = alt_out_i[0]; oe_n = alt_oe_i[0]; end
      MODE_ALT_B: begin out_o = alt_out_i[1]; oe_n = alt_oe_i[1]; end
      MODE_ALT_C: begin out_o = alt_out_i[2]; oe_n = alt_oe_i[2]; end
      default:    begin out_o = dout_i;       oe_n = dir_i;       end
    endcase
  end

  // sleep override turns the pin into a pulled input
  assign force_in  = sleep_i & ~keep_i;
  assign oe_o      = oe_n & ~force_in;
  assign pull_en_o = force_in | (~pdis_i & ~oe_n);
  assign pull_up_o = dout_i;
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_mux_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic                sleep_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pull_en_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  input  logic [NUM_PINS-1:0] alt_a_out_i,
  input  logic [NUM_PINS-1:0] alt_a_oe_i,
  input  logic [NUM_PINS-1:0] alt_b_out_i,
  input  logic [NUM_PINS-1:0] alt_b_oe_i,
  input  logic [NUM_PINS-1:0] alt_c_out_i,
  input  logic [NUM_PINS-1:0] alt_c_oe_i
);
  logic [NUM_PINS-1:0] dout_q, dir_q, pdis_q, keep_q, asel_q, bsel_q;
  logic [NUM_PINS-1:0] pad_sync;

  gmb_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (sel_i & we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .dout_q_o (dout_q),
    .dir_q_o  (dir_q),
    .pdis_q_o (pdis_q),
    .keep_q_o (keep_q),
    .asel_q_o (asel_q),
    .bsel_q_o (bsel_q)
  );

  gmb_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pad_sync)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    gmb_pin u_pin (
      .dout_i    (dout_q[n]),
      .dir_i     (dir_q[n]),
      .pdis_i    (pdis_q[n]),
      .keep_i    (keep_q[n]),
      .asel_i    (asel_q[n]),
      .bsel_i    (bsel_q[n]),
      .sleep_i   (sleep_i),
      .alt_out_i ({alt_c_out_i[n], alt_b_out_i[n], alt_a_out_i[n]}),
      .alt_oe_i  ({alt_c_oe_i[n], alt_b_oe_i[n], alt_a_oe_i[n]}),
      .out_o     (pad_out_o[n]),
      .oe_o      (pad_oe_o[n]),
      .pull_en_o (pull_en_o[n]),
      .pull_up_o (pull_up_o[n])
    );
  end

  always_comb begin
    case (addr_i)
      OFF_DATA:                          rdata_o = pad_sync;
      OFF_DSET, OFF_DCLR:                rdata_o = dout_q;
      OFF_PDIS:                          rdata_o = pdis_q;
      OFF_DIR, OFF_DIRSET, OFF_DIRCLR:   rdata_o = dir_q;
      OFF_SLEEP:                         rdata_o = keep_q;
      OFF_ASEL:                          rdata_o = asel_q;
      OFF_BSEL:                          rdata_o = bsel_q;
      default:                           rdata_o = '0;
    endcase
  end

  AST_SLEEP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> ((pad_oe_o & ~keep_q) == '0) && ((pull_en_o | keep_q) == '1)); // R9

  AST_PULL_NOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & pad_oe_o) == '0); // R8

  AST_PULL_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && addr_i == OFF_DSET) |=> ((pull_up_o & $past(wdata_i)) == $past(wdata_i))); // R8
endmodule

// File: tb/tb_gpio_mux_bank.sv
module tb_gpio_mux_bank;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel = 1'b0, we = 1'b0, sleep = 1'b0;
  logic [3:0]   addr = '0;
  logic [N-1:0] wdata = '0, rdata, pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pull_en, pull_up;
  logic [N-1:0] a_out = '0, a_oe = '0, b_out = '0, b_oe = '0, c_out = '0, c_oe = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [N-1:0] m_dout, m_dir, m_pdis, m_keep, m_asel, m_bsel;

  always #10 clk = ~clk;

  gpio_mux_bank #(.NUM_PINS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sleep_i(sleep), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pull_en_o(pull_en), .pull_up_o(pull_up),
    .alt_a_out_i(a_out), .alt_a_oe_i(a_oe), .alt_b_out_i(b_out), .alt_b_oe_i(b_oe),
    .alt_c_out_i(c_out), .alt_c_oe_i(c_oe)
  );

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_read(logic [3:0] a);
    case (a)
      4'd1, 4'd2:       return m_dout;
      4'd3:             return m_pdis;
      4'd4, 4'd5, 4'd6: return m_dir;
      4'd7:             return m_keep;
      4'd8:             return m_asel;
      4'd9:             return m_bsel;
      default:          return '0;
    endcase
  endfunction

  // per-pin driven value and enable before the sleep override (R6, R7)
  function automatic logic [2*N-1:0] exp_drive();
    logic [N-1:0] o, e;
    for (int n = 0; n < N; n++) begin
      case ({m_bsel[n], m_asel[n]})
        2'b01:   begin o[n] = a_out[n]; e[n] = a_oe[n]; end
        2'b10:   begin o[n] = b_out[n]; e[n] = b_oe[n]; end
        2'b11:   begin o[n] = c_out[n]; e[n] = c_oe[n]; end
        default: begin o[n] = m_dout[n]; e[n] = m_dir[n]; end
      endcase
    end
    return {o, e};
  endfunction

  task automatic check_pins(string ctx);
    logic [2*N-1:0] d;
    logic [N-1:0] frc, e, pe;
    d   = exp_drive();
    frc = sleep ? ~m_keep : '0;
    e   = d[N-1:0] & ~frc;
    pe  = frc | (~m_pdis & ~d[N-1:0]);
    check({"R6/R7 pad_out ", ctx}, pad_out, d[2*N-1:N]);
    check({"R6/R7/R9 pad_oe ", ctx}, pad_oe, e);
    check({"R8/R9 pull_en ", ctx}, pull_en, pe);
    check({"R8 pull_up ", ctx}, pull_up, m_dout);
  endtask

  task automatic write(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    case (a)
      4'd0: m_dout = d;
      4'd1: m_dout = m_dout | d;
      4'd2: m_dout = m_dout & ~d;
      4'd3: m_pdis = d;
      4'd4: m_dir  = d;
      4'd5: m_dir  = m_dir | d;
      4'd6: m_dir  = m_dir & ~d;
      4'd7: m_keep = d;
      4'd8: m_asel = d;
      4'd9: m_bsel = d;
      default: ;
    endcase
  endtask

  task automatic read_check(string tag, logic [3:0] a);
    addr = a;
    #2;
    check(tag, rdata, exp_read(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_dout = '0; m_dir = '0; m_pdis = '1; m_keep = '1; m_asel = '0; m_bsel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pull_en", pull_en, '0);
    for (int a = 1; a < 10; a++) read_check("R1 readback", 4'(a));

    // R2 set/clear with masked bits
    write(4'd0, 32'hF0F0_00FF);
    read_check("R3 data load", 4'd1);
    write(4'd1, 32'h0000_FF00);
    read_check("R2 set", 4'd1);
    check("R2 set value", rdata, 32'hF0F0_FFFF);
    write(4'd2, 32'hF000_000F);
    read_check("R2 clear", 4'd2);
    check("R2 clear value", rdata, 32'h00F0_FFF0);
    write(4'd1, '0);
    read_check("R2 zero set ignored", 4'd1);
    write(4'd2, '0);
    read_check("R2 zero clear ignored", 4'd1);

    // R4 direction
    write(4'd4, 32'h1234_5678);
    read_check("R4 dir load", 4'd4);
    write(4'd5, 32'h8000_0001);
    read_check("R4 dir set", 4'd5);
    write(4'd6, 32'h0000_0078);
    read_check("R4 dir clear", 4'd6);
    check_pins("gpio directed");

    // R5 mode select: pins 0..3 take modes 00,01,10,11
    a_out = 32'h0000_0002; a_oe = 32'h0000_0002;
    b_out = 32'h0000_0000; b_oe = 32'h0000_0004;
    c_out = 32'h0000_0008; c_oe = 32'h0000_0008;
    write(4'd8, 32'h0000_000A);
    write(4'd9, 32'h0000_000C);
    read_check("R5 asel", 4'd8);
    read_check("R5 bsel", 4'd9);
    check_pins("alt directed");

    // R8 pull enabled on non-driving pins
    write(4'd3, 32'h0000_0000);
    check_pins("pull directed");

    // R9 sleep override
    write(4'd7, 32'hFFFF_0000);
    sleep = 1'b1;
    #2 check_pins("sleep directed");
    check("R9 low half pulled", pull_en & 32'h0000_FFFF, 32'h0000_FFFF);
    sleep = 1'b0;

    // R11 unmapped offsets
    for (int a = 10; a < 16; a++) begin
      write(4'(a), '1);
      read_check("R11 unmapped read", 4'(a));
    end
    for (int a = 0; a < 10; a++) if (a != 0) read_check("R11 regs untouched", 4'(a));
    check_pins("R11 after unmapped writes");

    // R10 synchronizer latency
    @(negedge clk);
    pad_in = 32'hA5C3_0F96;
    addr = 4'd0;
    @(posedge clk);
    @(negedge clk);
    check("R10 not after one edge", rdata, 32'h0000_0000);
    @(posedge clk);
    @(negedge clk);
    check("R10 visible after two edges", rdata, 32'hA5C3_0F96);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic [N-1:0] d;
      a = 4'($urandom_range(0, 15));
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = N'(1) << $urandom_range(0, N-1);
      write(a, d);
      sleep = ($urandom_range(0, 2) == 0);
      a_out = $urandom(); a_oe = $urandom();
      b_out = $urandom(); b_oe = $urandom();
      c_out = $urandom(); c_oe = $urandom();
      #2 check_pins("random");
      read_check("R2/R4/R5 random readback", 4'($urandom_range(1, 15)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule